// File: doc/BRIEF.md
# Tiled Systolic Matrix Multiplier

This block computes the product of two 8x8 matrices of 32-bit unsigned elements using a single 4x4 output-stationary systolic array, which it reuses for every quadrant product. Software or a neighbouring block fills the two operand memories through their write ports and then pulses `start`. Each operand is treated as four 4x4 quadrants: top-left (index 0), top-right (1), bottom-left (2) and bottom-right (3). Each output quadrant is the sum of two quadrant products. For example, the top-left output is the product of the top-left A and top-left B quadrants plus the product of the top-right A and bottom-left B quadrants.

For each output quadrant, the sequencer runs two passes through the array. Before each pass, a skew stage staggers the A rows and B columns. The array accumulators are cleared at the first pass of a quadrant and keep their contents through the second, so the sum of the two partial products forms inside the array. A write-back stage then copies the sixteen finished elements into the result memory one per cycle. The output quadrants are processed in the order top-left, top-right, bottom-left, bottom-right. A one-cycle `done` pulse marks the end of the run. The result memory has its own read port, which can be used at any time.

Top module: `tile_matmul`

## Requirements
- R1: Operand element (row r, column c) is written at address 8r+c when its write enable is high at a rising clock edge. The A and B write ports are independent, and the write order has no effect on the result.
- R2: After a run, result address 8r+c holds the sum over k of A(r,k)·B(k,c), with every product and sum taken modulo 2^32 as unsigned integers.
- R3: Every run starts from cleared accumulators, so a result never contains any part of an earlier run or an earlier quadrant.
- R4: A `start` that is high while a run is in progress is ignored. It does not restart the run or move the timing of `done`.
- R5: `done` is high for exactly one cycle, beginning at the 144th rising edge after the edge that sampled `start` in the idle state. At all other times it is low.
- R6: `c_rdata` is registered. It shows the content of address `c_raddr` as it was at the previous rising edge, and reads are allowed during a run.
- R7: After a synchronous active-low reset, `done` is low and the block is idle and accepts `start`.
- R8: Output quadrant q (0..3) writes its element w into the result memory at the rising edge 36q+21+w after the accepting edge. Here w runs from 0 to 15, row-major within the quadrant (row w/4, column w%4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a multiply when the block is idle |
| a_we | input | 1 | Write enable for operand A memory |
| a_waddr | input | 6 | Operand A address, 8·row+column |
| a_wdata | input | 32 | Operand A element |
| b_we | input | 1 | Write enable for operand B memory |
| b_waddr | input | 6 | Operand B address, 8·row+column |
| b_wdata | input | 32 | Operand B element |
| c_raddr | input | 6 | Result memory read address, 8·row+column |
| c_rdata | output | 32 | Result element, one cycle after the address |
| done | output | 1 | One-cycle pulse when all results are stored |

## Verification
The result memory is written on a fixed schedule, so a wrong internal state shows up at the read port very soon. A skew or feed error corrupts the elements of the quadrant being computed, and a stale accumulator corrupts the first element of the next quadrant. Either fault appears at the read port by edge 36q+21, at most 36 cycles after the cause. A counting error in the sequencer moves the `done` pulse away from edge 144, and it also shifts every later write. The bench therefore sweeps the read address during each run and compares the result memory against its own model on every cycle, instead of checking only after `done`.

// File: rtl/tmm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the tiled matrix multiplier.
// Assumes the tile size is a power of two that divides the matrix size.
package tmm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_WRITE = 2'd2
    } tmm_state_e;

    // Number of cycles one pass needs until the last processing element has updated.
    function automatic int pass_cycles(input int tile);
        return 3 * tile - 2;
    endfunction

endpackage

// File: rtl/tmm_skew.sv
`timescale 1ns/1ps
// Stagger stage: lane i of the output is lane i of the input delayed by i cycles.
// Assumes inputs are zero outside the feed window, so the delay lines flush with zeros.
module tmm_skew #(
    parameter int DW = 32,
    parameter int T  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [T-1:0][DW-1:0] lane_in,
    output logic [T-1:0][DW-1:0] lane_out
);

    for (genvar i = 0; i < T; i++) begin : g_lane
        if (i == 0) begin : g_pass
            assign lane_out[i] = lane_in[i];
        end else begin : g_delay
            logic [DW-1:0] sr [i];

            // Shift the lane value through i registers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < i; s++) sr[s] <= '0;
                end else begin
                    sr[0] <= lane_in[i];
                    for (int s = 1; s < i; s++) sr[s] <= sr[s-1];
                end
            end

            assign lane_out[i] = sr[i-1];
        end
    end

endmodule

// File: rtl/tmm_array.sv
`timescale 1ns/1ps
// Output-stationary TxT systolic array. Each cell multiplies its A and B inputs,
// adds the product to its accumulator (or loads it when clr is high) and forwards
// A to the right and B downward. Arithmetic wraps at DW bits. Assumes T >= 2.
module tmm_array #(
    parameter int DW = 32,
    parameter int T  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic [T-1:0][DW-1:0]         a_lane,
    input  logic [T-1:0][DW-1:0]         b_lane,
    output logic [T-1:0][T-1:0][DW-1:0]  acc
);

    logic [T-1:0][T-2:0][DW-1:0] a_pipe;
    logic [T-2:0][T-1:0][DW-1:0] b_pipe;

    for (genvar r = 0; r < T; r++) begin : g_row
        for (genvar c = 0; c < T; c++) begin : g_col
            logic [DW-1:0] a_in, b_in, prod, acc_q;

            if (c == 0) begin : g_aw
                assign a_in = a_lane[r];
            end else begin : g_ai
                assign a_in = a_pipe[r][c-1];
            end

            if (r == 0) begin : g_bn
                assign b_in = b_lane[c];
            end else begin : g_bi
                assign b_in = b_pipe[r-1][c];
            end

            assign prod = a_in * b_in;

            // Accumulate the product of this cell's inputs.
            always_ff @(posedge clk) begin
                if (!rst_n)   acc_q <= '0;
                else if (clr) acc_q <= prod;
                else          acc_q <= acc_q + prod;
            end
            assign acc[r][c] = acc_q;

            if (c < T - 1) begin : g_fa
                logic [DW-1:0] a_q;
                // Forward A to the cell on the right.
                always_ff @(posedge clk) begin
                    if (!rst_n) a_q <= '0;
                    else        a_q <= a_in;
                end
                assign a_pipe[r][c] = a_q;
            end

            if (r < T - 1) begin : g_fb
                logic [DW-1:0] b_q;
                // Forward B to the cell below.
                always_ff @(posedge clk) begin
                    if (!rst_n) b_q <= '0;
                    else        b_q <= b_in;
                end
                assign b_pipe[r][c] = b_q;
            end
        end
    end

endmodule

// File: rtl/tile_matmul.sv
`timescale 1ns/1ps
// Tiled matrix multiplier: MAT_N x MAT_N product using one TILE_N x TILE_N
// systolic array time-shared over QN*QN output quadrants, QN passes each.
// Holds both operands and the result in register-file memories. Assumes
// MAT_N is a multiple of TILE_N, both powers of two, and TILE_N >= 2.
module tile_matmul #(
    parameter int DATA_W = 32,
    parameter int MAT_N  = 8,
    parameter int TILE_N = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic                             a_we,
    input  logic [$clog2(MAT_N*MAT_N)-1:0]   a_waddr,
    input  logic [DATA_W-1:0]                a_wdata,
    input  logic                             b_we,
    input  logic [$clog2(MAT_N*MAT_N)-1:0]   b_waddr,
    input  logic [DATA_W-1:0]                b_wdata,
    input  logic [$clog2(MAT_N*MAT_N)-1:0]   c_raddr,
    output logic [DATA_W-1:0]                c_rdata,
    output logic                             done
);
    import tmm_pkg::*;

    localparam int AW = $clog2(MAT_N * MAT_N);
    localparam int QN = MAT_N / TILE_N;
    localparam int QW = (QN * QN > 1) ? $clog2(QN * QN) : 1;
    localparam int KW = (QN > 1) ? $clog2(QN) : 1;
    localparam int PC = pass_cycles(TILE_N);
    localparam int CW = $clog2(PC);
    localparam int TW = $clog2(TILE_N);
    localparam int WW = 2 * TW;

    logic [DATA_W-1:0] a_mem [MAT_N*MAT_N];
    logic [DATA_W-1:0] b_mem [MAT_N*MAT_N];
    logic [DATA_W-1:0] c_mem [MAT_N*MAT_N];

    tmm_state_e  state;
    logic [QW-1:0] quad;
    logic [KW-1:0] kp;
    logic [CW-1:0] cyc;
    logic [WW-1:0] widx;
    logic          done_q;

    logic          feeding, clr, c_we;
    logic [AW-1:0] c_waddr;
    logic [DATA_W-1:0] wr_data;
    int            qi, qj;

    logic [TILE_N-1:0][DATA_W-1:0]              a_col, b_row, a_lane, b_lane;
    logic [TILE_N-1:0][TILE_N-1:0][DATA_W-1:0]  acc;

    // Operand memory write ports.
    always_ff @(posedge clk) begin
        if (a_we) a_mem[a_waddr] <= a_wdata;
        if (b_we) b_mem[b_waddr] <= b_wdata;
    end

    assign qi      = int'(quad) / QN;
    assign qj      = int'(quad) % QN;
    assign feeding = (state == ST_RUN) && (cyc < CW'(TILE_N));
    assign clr     = (state == ST_RUN) && (kp == '0) && (cyc == '0);

    // Select one A column and one B row of the current tile pair, zero outside the feed window.
    always_comb begin
        for (int r = 0; r < TILE_N; r++) begin
            a_col[r] = '0;
            b_row[r] = '0;
            if (feeding) begin
                a_col[r] = a_mem[AW'((qi * TILE_N + r) * MAT_N + int'(kp) * TILE_N + int'(cyc))];
                b_row[r] = b_mem[AW'((int'(kp) * TILE_N + int'(cyc)) * MAT_N + qj * TILE_N + r)];
            end
        end
    end

    tmm_skew #(.DW(DATA_W), .T(TILE_N)) u_skew_a (
        .clk(clk), .rst_n(rst_n), .lane_in(a_col), .lane_out(a_lane)
    );

    tmm_skew #(.DW(DATA_W), .T(TILE_N)) u_skew_b (
        .clk(clk), .rst_n(rst_n), .lane_in(b_row), .lane_out(b_lane)
    );

    tmm_array #(.DW(DATA_W), .T(TILE_N)) u_array (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .a_lane(a_lane), .b_lane(b_lane), .acc(acc)
    );

    // Sequencer: quadrant, pass, cycle within pass, and write-back index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            quad   <= '0;
            kp     <= '0;
            cyc    <= '0;
            widx   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        quad  <= '0;
                        kp    <= '0;
                        cyc   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cyc == CW'(PC - 1)) begin
                        cyc <= '0;
                        if (kp == KW'(QN - 1)) begin
                            kp    <= '0;
                            widx  <= '0;
                            state <= ST_WRITE;
                        end else begin
                            kp <= kp + KW'(1);
                        end
                    end else begin
                        cyc <= cyc + CW'(1);
                    end
                end
                ST_WRITE: begin
                    if (widx == WW'(TILE_N * TILE_N - 1)) begin
                        widx <= '0;
                        if (quad == QW'(QN * QN - 1)) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            quad  <= quad + QW'(1);
                            state <= ST_RUN;
                        end
                    end else begin
                        widx <= widx + WW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign c_we    = (state == ST_WRITE);
    assign c_waddr = AW'((qi * TILE_N + int'(widx[WW-1:TW])) * MAT_N + qj * TILE_N + int'(widx[TW-1:0]));
    assign wr_data = acc[widx[WW-1:TW]][widx[TW-1:0]];

    // Result memory: write-back port and registered read port.
    always_ff @(posedge clk) begin
        if (c_we) c_mem[c_waddr] <= wr_data;
        c_rdata <= c_mem[c_raddr];
    end

    assign done = done_q;

endmodule

// File: rtl/tmm_checker.sv
`timescale 1ns/1ps
// Property checker for tile_matmul, attached by bind. Observes the sequencer,
// the stagger stage and the accumulators; drives nothing in the design.
module tmm_checker #(
    parameter int DW = 32,
    parameter int T  = 4,
    parameter int N  = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          done,
    input tmm_pkg::tmm_state_e           state,
    input logic [$clog2(3*T-2)-1:0]      cyc,
    input logic [T-1:0][T-1:0][DW-1:0]   acc,
    input logic [T-1:0][DW-1:0]          a_col,
    input logic [T-1:0][DW-1:0]          a_lane
);
    import tmm_pkg::*;

    localparam int QN    = N / T;
    localparam int PC    = pass_cycles(T);
    localparam int CW    = $clog2(PC);
    localparam int TOTAL = QN * QN * (QN * PC + T * T);

    int unsigned lat_cnt;

    // Count cycles since the accepting edge of start.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lat_cnt <= 0;
        else if (state == ST_IDLE && start)  lat_cnt <= 1;
        else if (done)                       lat_cnt <= 0;
        else if (lat_cnt != 0)               lat_cnt <= lat_cnt + 1;
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lat_cnt == TOTAL + 1);

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start && cyc != CW'(PC - 1)) |=> cyc == $past(cyc) + CW'(1));

    // R3
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) != ST_RUN) |=> acc[T-1][T-1] == '0);

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRITE |=> $stable(acc));

    // R2
    skew_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |=> a_lane[1] == $past(a_col[1]));

endmodule

bind tile_matmul tmm_checker #(.DW(DATA_W), .T(TILE_N), .N(MAT_N)) u_tmm_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .state(state),
    .cyc(cyc), .acc(acc), .a_col(a_col), .a_lane(a_lane)
);

// File: tb/tile_matmul_bench.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural cycle model of the result memory and done,
// compared on every clock, plus explicit result sweeps after each run.
module tile_matmul_bench;
    localparam int N        = 8;
    localparam int T        = 4;
    localparam int NN       = N * N;
    localparam int QN       = N / T;
    localparam int RUN_LEN  = QN * (3 * T - 2);
    localparam int QUAD_LEN = RUN_LEN + T * T;
    localparam int TOTAL    = QN * QN * QUAD_LEN;

    logic        clk, rst_n, start;
    logic        a_we, b_we;
    logic [5:0]  a_waddr, b_waddr, c_raddr;
    logic [31:0] a_wdata, b_wdata, c_rdata;
    logic        done;

    tile_matmul u_tile_matmul (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_we(a_we), .a_waddr(a_waddr), .a_wdata(a_wdata),
        .b_we(b_we), .b_waddr(b_waddr), .b_wdata(b_wdata),
        .c_raddr(c_raddr), .c_rdata(c_rdata), .done(done)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    int unsigned sa [NN];
    int unsigned sb [NN];
    int unsigned ma [NN];
    int unsigned mb [NN];
    int unsigned ref_c [NN];
    int unsigned exp_c [NN];
    bit          known [NN];
    bit          busy_m = 1'b0;
    bit          done_exp = 1'b0;
    bit          exp_rvalid = 1'b0;
    int unsigned exp_rdata;
    int          t_m = 0;
    bit          mon_on = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // Cycle model: operand copies, schedule of result writes, done timing.
    always @(posedge clk) begin
        int u, q, off, w, addr;
        int unsigned s;
        if (!rst_n) begin
            busy_m     = 1'b0;
            t_m        = 0;
            done_exp   = 1'b0;
            exp_rvalid = 1'b0;
        end else begin
            exp_rvalid = known[c_raddr];
            exp_rdata  = exp_c[c_raddr];
            if (a_we) ma[a_waddr] = a_wdata;
            if (b_we) mb[b_waddr] = b_wdata;
            done_exp = 1'b0;
            if (busy_m) begin
                t_m++;
                u   = t_m - 1;
                q   = u / QUAD_LEN;
                off = u % QUAD_LEN;
                if (off >= RUN_LEN) begin
                    w    = off - RUN_LEN;
                    addr = ((q / QN) * T + w / T) * N + (q % QN) * T + w % T;
                    exp_c[addr] = ref_c[addr];
                    known[addr] = 1'b1;
                end
                if (t_m == TOTAL) begin
                    done_exp = 1'b1;
                    busy_m   = 1'b0;
                end
            end else if (start) begin
                busy_m = 1'b1;
                t_m    = 0;
                for (int i = 0; i < N; i++) begin
                    for (int j = 0; j < N; j++) begin
                        s = 0;
                        for (int k = 0; k < N; k++) s += ma[i*N+k] * mb[k*N+j];
                        ref_c[i*N+j] = s;
                    end
                end
            end
        end
    end

    // Every-cycle comparison of done and the read port against the model.
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check(done === done_exp, "R5", "done per cycle", {31'd0, done}, {31'd0, done_exp});
            if (exp_rvalid)
                check(c_rdata === exp_rdata, "R6/R8", "result read per cycle", c_rdata, exp_rdata);
        end
    end

    task automatic load(input bit reverse);
        for (int i = 0; i < NN; i++) begin
            @(negedge clk);
            a_we    = 1'b1;
            b_we    = 1'b1;
            a_waddr = 6'(reverse ? NN - 1 - i : i);
            b_waddr = 6'(reverse ? NN - 1 - i : i);
            a_wdata = sa[reverse ? NN - 1 - i : i];
            b_wdata = sb[reverse ? NN - 1 - i : i];
        end
        @(negedge clk);
        a_we = 1'b0;
        b_we = 1'b0;
    endtask

    // Start a run, sweep the read address, optionally pulse start while busy.
    task automatic run(input bit inject);
        int i;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        i = 0;
        while (done !== 1'b1 && i < TOTAL + 20) begin
            c_raddr = 6'((c_raddr + 1) % NN);
            // R4: start pulses inside the run, including the edge of the last write
            start = inject && (i == 3 || i == 50 || i == TOTAL - 1);
            @(negedge clk);
            i++;
        end
        start = 1'b0;
        check(i == TOTAL, "R5", "done position after start", 32'(i), 32'(TOTAL));
    endtask

    // mode 0: reference product, 1: equal to B, 2: constant value
    task automatic sweep(input string tag, input int mode, input int unsigned cval);
        int unsigned e;
        for (int a = 0; a < NN; a++) begin
            @(negedge clk);
            c_raddr = 6'(a);
            @(negedge clk);
            e = (mode == 0) ? ref_c[a] : (mode == 1) ? sb[a] : cval;
            check(c_rdata === e, tag, $sformatf("result addr %0d", a), c_rdata, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R5 watchdog: got %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; a_we = 1'b0; b_we = 1'b0;
        a_waddr = '0; b_waddr = '0; a_wdata = '0; b_wdata = '0; c_raddr = '0;
        for (int i = 0; i < NN; i++) known[i] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: idle after reset, done low
        check(done === 1'b0, "R7", "done after reset", {31'd0, done}, 32'd0);
        mon_on = 1'b1;

        // R2 R4: random operands, start pulsed while busy
        for (int i = 0; i < NN; i++) begin sa[i] = $urandom; sb[i] = $urandom; end
        load(1'b0);
        run(1'b1);
        sweep("R2", 0, 0);

        // R1: identity A, random B, loaded in descending address order
        for (int i = 0; i < NN; i++) begin
            sa[i] = (i / N == i % N) ? 32'd1 : 32'd0;
            sb[i] = $urandom;
        end
        load(1'b1);
        run(1'b0);
        sweep("R1", 1, 0);

        // R2: all-ones operands wrap to 8 per element
        for (int i = 0; i < NN; i++) begin sa[i] = 32'hFFFF_FFFF; sb[i] = 32'hFFFF_FFFF; end
        load(1'b0);
        run(1'b0);
        sweep("R2", 2, 32'd8);

        // R3: zero A after a nonzero run leaves no residue
        for (int i = 0; i < NN; i++) begin sa[i] = 32'd0; sb[i] = $urandom; end
        load(1'b0);
        run(1'b0);
        sweep("R3", 2, 32'd0);

        // R3 R4: fresh random run with busy starts
        for (int i = 0; i < NN; i++) begin sa[i] = $urandom % 1000; sb[i] = $urandom; end
        load(1'b0);
        run(1'b1);
        sweep("R3", 0, 0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule